// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block controls a parameterised number of general-purpose pins (a multiple of 32, normally 64 or 96). Software uses a single-cycle register port to select each pin's direction and to set or clear its output level. It can read back the synchronised pin levels, arm rising and falling edge detection separately for each pin, and collect detected edges in sticky status bits. One interrupt line is high while any status bit is set. A 2-bit field per pin hands the pin over to an alternate-function source, whose data and enable arrive on separate input ports.

Registers are grouped by feature. Each one-bit-per-pin feature takes one 32-bit word per bank of 32 pins, and the banks of a feature sit in consecutive words. The word index is `kind * NREG + bank`, where `NREG = pins / 32`, and pin p sits at bit p%32 of bank p/32. The kinds are 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable and 6 edge status. Kind 7 holds the alternate-function fields, 16 pins per word. Reads are combinational and appear on `reg_rdata` in the same cycle as the address. Writes take effect at the next clock edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Byte address `4*(kind*NREG+bank)` reaches the word of that kind for pins 32*bank..32*bank+31, with pin p at bit p%32. A read of the level kind returns `pin_in` after it has passed through two register stages, so it becomes visible two clock edges after the input changes.
- R2: Writes to the level words change nothing. The set and clear words always read 0.
- R3: A write to the set word forces output data high for every 1 bit. A write to the clear word forces it low for every 1 bit. Bits written as 0 leave output data unchanged.
- R4: Direction bit 1 makes the pin an output. For a pin whose alternate-function field is 0, `pin_oe` equals the direction bit and `pin_out` equals the output data bit.
- R5: The rising and falling enables act independently. An enabled edge of the synchronised level sets the pin's status bit one clock after the level changes. An edge of a kind that is not enabled sets nothing.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits stay set until they are cleared.
- R7: If an enabled edge arrives in the same cycle as a write-one-to-clear of the same status bit, the bit ends up set.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: Pin p's 2-bit alternate-function field sits in word `7*NREG + p/16`, at bits `(p%16)*2+1:(p%16)*2`, and reads back as written. When the field is nonzero, `pin_out` and `pin_oe` come from `alt_out[p]` and `alt_oe[p]`.
- R10: After reset all pins are inputs, and output data, edge enables, status and alternate-function fields are all 0.
- R11: Addresses beyond the last alternate-function word, and addresses whose two low bits are not 00, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Pin output data |
| pin_oe | output | NUM_PINS | Pin output enable |
| alt_out | input | NUM_PINS | Alternate-function output data |
| alt_oe | input | NUM_PINS | Alternate-function output enable |
| irq | output | 1 | Aggregated edge interrupt |

## Verification
The hardest case to reach is the collision in R7, where an edge and a clear of an already-set status bit hit the register in the same cycle. From the ports this means counting the synchroniser stages. The bench sets the bit with one edge, toggles the pin back on a falling clock, waits two rising edges and then issues the status write, so the write lands on the same edge as the detected edge. A cycle-accurate behavioural model is compared on every clock during a long stretch of pseudo-random pin toggling mixed with random status clears. This also produces many clears that coincide with edges.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int WORD_BITS = 32;
   localparam int AF_BITS   = 2;

   // Feature order decides the word layout; neighbours decode it.
   typedef enum logic [2:0] {
      KIND_LEVEL  = 3'd0,
      KIND_DIR    = 3'd1,
      KIND_SET    = 3'd2,
      KIND_CLR    = 3'd3,
      KIND_RISE   = 3'd4,
      KIND_FALL   = 3'd5,
      KIND_STATUS = 3'd6,
      KIND_ALTFN  = 3'd7
   } reg_kind_e;

   function automatic int word_index(reg_kind_e kind, int bank, int nreg);
      return int'(kind) * nreg + bank;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] level,
   output logic [NUM_PINS-1:0] rise,
   output logic [NUM_PINS-1:0] fall
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[SYNC_STAGES-1];
   end

   assign level = stage_q[SYNC_STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int NUM_PINS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] rise,
   input  logic [NUM_PINS-1:0] fall,
   input  logic [NUM_PINS-1:0] rise_en,
   input  logic [NUM_PINS-1:0] fall_en,
   input  logic [NUM_PINS-1:0] clr_mask,
   output logic [NUM_PINS-1:0] status_q,
   output logic                irq
);

   logic [NUM_PINS-1:0] hit;

   assign hit = (rise & rise_en) | (fall & fall_en);

   // Edge term is OR-ed last so a coincident clear cannot drop it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_mask) | hit;
   end

   assign irq = |status_q;

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q != '0) |=> (($past(status_q & ~clr_mask) & ~status_q) == '0)) // R6
      else $error("status bit dropped without a clear");

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ~hit) != '0) |=> ((status_q & $past(clr_mask & ~hit)) == '0)) // R6
      else $error("cleared status bit still set");

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((status_q & $past(hit)) == $past(hit))) // R7
      else $error("detected edge lost");

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int NUM_PINS = 64
) (
   input  logic [NUM_PINS-1:0]   dout,
   input  logic [NUM_PINS-1:0]   dir,
   input  logic [2*NUM_PINS-1:0] af_sel,
   input  logic [NUM_PINS-1:0]   alt_out,
   input  logic [NUM_PINS-1:0]   alt_oe,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic plain;
      assign plain      = (af_sel[2*p +: 2] == 2'b00);
      assign pin_out[p] = plain ? dout[p] : alt_out[p];
      assign pin_oe[p]  = plain ? dir[p]  : alt_oe[p];
   end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic [NUM_PINS-1:0] alt_out,
   input  logic [NUM_PINS-1:0] alt_oe,
   output logic                irq
);

   localparam int NREG      = NUM_PINS / WORD_BITS;
   localparam int AF_WORDS  = NUM_PINS * AF_BITS / WORD_BITS;
   localparam int NUM_WORDS = 7 * NREG + AF_WORDS;
   localparam int WIDX_W    = ADDR_W - 2;
   localparam int AF_BASE   = 7 * NREG;

   if (NUM_PINS % WORD_BITS != 0 || NUM_PINS < WORD_BITS) begin : g_bad_pins
      $error("gpio_bank_ctrl: NUM_PINS must be a nonzero multiple of 32");
   end
   if ((1 << WIDX_W) < NUM_WORDS) begin : g_bad_addr
      $error("gpio_bank_ctrl: ADDR_W too small for the register map");
   end

   logic [WIDX_W-1:0] widx;
   logic              aligned;
   logic              wr_ok;

   assign widx    = reg_addr[ADDR_W-1:2];
   assign aligned = (reg_addr[1:0] == 2'b00);
   assign wr_ok   = reg_wr && aligned;

   logic [NREG-1:0]     we_dir, we_set, we_clr, we_rise, we_fall, we_stat;
   logic [AF_WORDS-1:0] we_af;
   logic [NUM_PINS-1:0] set_bits, clr_bits, stat_clr;

   for (genvar b = 0; b < NREG; b++) begin : g_bank
      assign we_dir[b]  = wr_ok && (int'(widx) == word_index(KIND_DIR,    b, NREG));
      assign we_set[b]  = wr_ok && (int'(widx) == word_index(KIND_SET,    b, NREG));
      assign we_clr[b]  = wr_ok && (int'(widx) == word_index(KIND_CLR,    b, NREG));
      assign we_rise[b] = wr_ok && (int'(widx) == word_index(KIND_RISE,   b, NREG));
      assign we_fall[b] = wr_ok && (int'(widx) == word_index(KIND_FALL,   b, NREG));
      assign we_stat[b] = wr_ok && (int'(widx) == word_index(KIND_STATUS, b, NREG));
      assign set_bits[b*WORD_BITS +: WORD_BITS] = we_set[b]  ? reg_wdata : '0;
      assign clr_bits[b*WORD_BITS +: WORD_BITS] = we_clr[b]  ? reg_wdata : '0;
      assign stat_clr[b*WORD_BITS +: WORD_BITS] = we_stat[b] ? reg_wdata : '0;
   end

   for (genvar a = 0; a < AF_WORDS; a++) begin : g_afw
      assign we_af[a] = wr_ok && (int'(widx) == AF_BASE + a);
   end

   logic [NUM_PINS-1:0]   dir_q, dout_q, rise_en_q, fall_en_q;
   logic [2*NUM_PINS-1:0] af_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q     <= '0;
         dout_q    <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         af_q      <= '0;
      end else begin
         dout_q <= (dout_q | set_bits) & ~clr_bits;
         for (int b = 0; b < NREG; b++) begin
            if (we_dir[b])  dir_q[b*WORD_BITS +: WORD_BITS]     <= reg_wdata;
            if (we_rise[b]) rise_en_q[b*WORD_BITS +: WORD_BITS] <= reg_wdata;
            if (we_fall[b]) fall_en_q[b*WORD_BITS +: WORD_BITS] <= reg_wdata;
         end
         for (int a = 0; a < AF_WORDS; a++) begin
            if (we_af[a]) af_q[a*WORD_BITS +: WORD_BITS] <= reg_wdata;
         end
      end
   end

   logic [NUM_PINS-1:0] level, rise, fall, status_q;

   gpio_in_sync #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .level  (level),
      .rise   (rise),
      .fall   (fall)
   );

   gpio_edge_status #(
      .NUM_PINS (NUM_PINS)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise),
      .fall     (fall),
      .rise_en  (rise_en_q),
      .fall_en  (fall_en_q),
      .clr_mask (stat_clr),
      .status_q (status_q),
      .irq      (irq)
   );

   gpio_pin_mux #(
      .NUM_PINS (NUM_PINS)
   ) u_mux (
      .dout    (dout_q),
      .dir     (dir_q),
      .af_sel  (af_q),
      .alt_out (alt_out),
      .alt_oe  (alt_oe),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         for (int b = 0; b < NREG; b++) begin
            if (int'(widx) == word_index(KIND_LEVEL, b, NREG))
               reg_rdata = level[b*WORD_BITS +: WORD_BITS];
            if (int'(widx) == word_index(KIND_DIR, b, NREG))
               reg_rdata = dir_q[b*WORD_BITS +: WORD_BITS];
            if (int'(widx) == word_index(KIND_RISE, b, NREG))
               reg_rdata = rise_en_q[b*WORD_BITS +: WORD_BITS];
            if (int'(widx) == word_index(KIND_FALL, b, NREG))
               reg_rdata = fall_en_q[b*WORD_BITS +: WORD_BITS];
            if (int'(widx) == word_index(KIND_STATUS, b, NREG))
               reg_rdata = status_q[b*WORD_BITS +: WORD_BITS];
         end
         for (int a = 0; a < AF_WORDS; a++) begin
            if (int'(widx) == AF_BASE + a)
               reg_rdata = af_q[a*WORD_BITS +: WORD_BITS];
         end
      end
   end

   AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits != '0) |=> ((dout_q & $past(set_bits)) == $past(set_bits))) // R3
      else $error("set write did not raise output data");

   AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits != '0) |=> ((dout_q & $past(clr_bits)) == '0)) // R3
      else $error("clear write did not lower output data");

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && (stat_clr == '0)) |=> irq) // R8
      else $error("interrupt dropped without a status clear");

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_PINS   = 64;
   localparam int ADDR_W     = 8;
   localparam int NREG       = NUM_PINS / 32;
   localparam int AF_BASE    = 7 * NREG;
   localparam int NUM_WORDS  = 9 * NREG;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                reg_wr = 1'b0;
   logic [ADDR_W-1:0]   reg_addr = '0;
   logic [31:0]         reg_wdata = '0;
   logic [31:0]         reg_rdata;
   logic [NUM_PINS-1:0] pin_in = '0;
   logic [NUM_PINS-1:0] pin_out, pin_oe;
   logic [NUM_PINS-1:0] alt_out = '0;
   logic [NUM_PINS-1:0] alt_oe = '0;
   logic                irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe),
      .irq(irq)
   );

   // Behavioural reference model
   logic [NUM_PINS-1:0]   m_s1, m_s2, m_prev, m_dir, m_dout, m_ren, m_fen, m_st;
   logic [2*NUM_PINS-1:0] m_af;

   always @(posedge clk or negedge rst_n) begin
      logic [NUM_PINS-1:0] hit, clr;
      int w, k, b;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_dout = '0;
         m_ren = '0; m_fen = '0; m_st = '0; m_af = '0;
      end else begin
         hit = (m_s2 & ~m_prev & m_ren) | (~m_s2 & m_prev & m_fen);
         clr = '0;
         if (reg_wr && reg_addr[1:0] == 2'b00) begin
            w = int'(reg_addr) / 4;
            if (w < AF_BASE) begin
               k = w / NREG;
               b = w % NREG;
               case (k)
                  1: m_dir[b*32 +: 32] = reg_wdata;
                  2: m_dout[b*32 +: 32] = m_dout[b*32 +: 32] | reg_wdata;
                  3: m_dout[b*32 +: 32] = m_dout[b*32 +: 32] & ~reg_wdata;
                  4: m_ren[b*32 +: 32] = reg_wdata;
                  5: m_fen[b*32 +: 32] = reg_wdata;
                  6: clr[b*32 +: 32] = reg_wdata;
                  default: ;
               endcase
            end else if (w < NUM_WORDS) begin
               m_af[(w-AF_BASE)*32 +: 32] = reg_wdata;
            end
         end
         m_st   = (m_st & ~clr) | hit;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
      end
   end

   function automatic logic [31:0] m_read(logic [ADDR_W-1:0] a);
      int w, k, b;
      if (a[1:0] != 2'b00) return '0;
      w = int'(a) / 4;
      if (w >= NUM_WORDS) return '0;
      if (w >= AF_BASE) return m_af[(w-AF_BASE)*32 +: 32];
      k = w / NREG;
      b = w % NREG;
      case (k)
         0: return m_s2[b*32 +: 32];
         1: return m_dir[b*32 +: 32];
         4: return m_ren[b*32 +: 32];
         5: return m_fen[b*32 +: 32];
         6: return m_st[b*32 +: 32];
         default: return '0;
      endcase
   endfunction

   task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the clock edge
   always begin
      logic [NUM_PINS-1:0] e_out, e_oe;
      @(negedge clk);
      #2;
      for (int p = 0; p < NUM_PINS; p++) begin
         e_out[p] = (m_af[2*p +: 2] == 2'b00) ? m_dout[p] : alt_out[p];
         e_oe[p]  = (m_af[2*p +: 2] == 2'b00) ? m_dir[p]  : alt_oe[p];
      end
      check("R3/R9 pin_out vs model", pin_out, e_out);
      check("R4/R9 pin_oe vs model", pin_oe, e_oe);
      check("R8 irq vs model", irq, (m_st != '0));
      check("R1 reg_rdata vs model", reg_rdata, m_read(reg_addr));
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_addr  = ADDR_W'(a);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_chk(int a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_addr = ADDR_W'(a);
      #2;
      check(tag, reg_rdata, exp);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      for (int w = 0; w < NUM_WORDS; w++) rd_chk(w*4, 32'h0, "R10 reset word");
      check("R10 reset pin_oe", pin_oe, '0);
      check("R10 reset pin_out", pin_out, '0);
      check("R10 reset irq", irq, 1'b0);

      // R3 / R4 set, clear, direction
      wr(8, 32'h0000_FFFF);
      wr(16, 32'h0000_00A5);
      wr(24, 32'h0000_0005);
      wr(20, 32'h0000_0100);                 // pin 40 high
      @(negedge clk); #2;
      check("R3 set then clear bank0", pin_out[31:0], 32'h0000_00A0);
      check("R3 set bank1 pin40", pin_out[40], 1'b1);
      check("R4 direction bank0", pin_oe[31:0], 32'h0000_FFFF);
      check("R4 bank1 stays input", pin_oe[63:32], 32'h0);
      wr(16, 32'h0);                         // zero bits: no change
      @(negedge clk); #2;
      check("R3 zero write no effect", pin_out[31:0], 32'h0000_00A0);

      // R1 / R2 level readback and read-only
      @(negedge clk);
      pin_in = {32'hCAFE_0001, 32'h1234_5678};
      wr(0, 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      rd_chk(0, 32'h1234_5678, "R2 level ignores write / R1 bank0");
      rd_chk(4, 32'hCAFE_0001, "R1 level bank1");
      rd_chk(16, 32'h0, "R2 set word reads 0");
      rd_chk(24, 32'h0, "R2 clear word reads 0");

      // R5 edge enables
      @(negedge clk);
      pin_in = '0;
      repeat (4) @(negedge clk);
      wr(32, 32'h0000_0008);                 // rise pin 3
      wr(44, 32'h0004_0008);                 // fall pin 35, pin 50
      wr(36, 32'h0004_0000);                 // rise pin 50
      @(negedge clk);
      pin_in[3]  = 1'b1;
      pin_in[35] = 1'b1;
      repeat (5) @(negedge clk);
      rd_chk(48, 32'h0000_0008, "R5 rising edge pin3");
      rd_chk(52, 32'h0, "R5 rise on fall-only pin35 ignored");
      check("R8 irq set", irq, 1'b1);
      @(negedge clk);
      pin_in[35] = 1'b0;
      repeat (5) @(negedge clk);
      rd_chk(52, 32'h0000_0008, "R5 falling edge pin35");

      // R6 write-one-to-clear
      wr(52, 32'h0);
      rd_chk(52, 32'h0000_0008, "R6 zero write keeps status");
      wr(52, 32'h0000_0008);
      rd_chk(52, 32'h0, "R6 one clears status");
      wr(48, 32'h0000_0008);
      rd_chk(48, 32'h0, "R6 bank0 cleared");
      check("R8 irq low when all clear", irq, 1'b0);

      // R7 edge coincides with clear
      @(negedge clk);
      pin_in[50] = 1'b1;
      repeat (5) @(negedge clk);
      rd_chk(52, 32'h0004_0000, "R5 both-edge pin50 rise");
      @(negedge clk);
      pin_in[50] = 1'b0;
      @(posedge clk);
      @(posedge clk);
      wr(52, 32'h0004_0000);                 // lands on the edge cycle
      rd_chk(52, 32'h0004_0000, "R7 edge wins over clear");
      wr(52, 32'h0004_0000);
      rd_chk(52, 32'h0, "R6 later clear succeeds");

      // R9 alternate function
      @(negedge clk);
      alt_out = '0;
      alt_oe  = 64'h0000_0000_0010_0000;
      wr(56, 32'h0000_0800);                 // pin 5 field = 2
      wr(60, 32'h0000_0300);                 // pin 20 field = 3
      @(negedge clk); #2;
      check("R9 pin5 out from alt", pin_out[5], 1'b0);
      check("R9 pin5 oe from alt", pin_oe[5], 1'b0);
      check("R9 pin20 oe from alt", pin_oe[20], 1'b1);
      check("R4 pin7 still plain", pin_out[7], 1'b1);
      rd_chk(60, 32'h0000_0300, "R9 field readback");

      // R11 unmapped and misaligned
      wr(NUM_WORDS*4, 32'hFFFF_FFFF);
      rd_chk(NUM_WORDS*4, 32'h0, "R11 unmapped reads 0");
      wr(9, 32'hFFFF_FFFF);
      rd_chk(8, 32'h0000_FFFF, "R11 misaligned write ignored");
      rd_chk(9, 32'h0, "R11 misaligned reads 0");

      // Random phase, compared cycle by cycle with the model
      wr(32, 32'hFFFF_FFFF); wr(36, 32'hFFFF_FFFF);
      wr(40, 32'hFFFF_FFFF); wr(44, 32'hFFFF_FFFF);
      lfsr = 32'hACE1_1234;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lfsr      = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         pin_in    = {lfsr ^ pin_in[63:32], ~lfsr[15:0] ^ pin_in[15:0], lfsr[31:16]};
         alt_out   = {lfsr, lfsr};
         reg_addr  = ADDR_W'(48 + 4 * (i % 2));
         reg_wdata = lfsr;
         reg_wr    = (i % 3 == 0);
      end
      @(negedge clk);
      reg_wr = 1'b0;
      wr(48, 32'hFFFF_FFFF);
      wr(52, 32'hFFFF_FFFF);
      @(negedge clk);
      pin_in = pin_in;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule